// File: doc/BRIEF.md
# Single-Butterfly Burst FFT Core

This block computes an N-point complex fast Fourier transform with the least datapath it can manage. It has one complex radix-2 butterfly and one frame memory. Samples arrive on a valid/ready stream. Each accepted sample is stored at the bit-reversed version of its arrival index. After the N-th sample is stored, the core lowers its ready output and runs the transform in place. It works through log2(N) decimation-in-time stages, and every butterfly of every stage goes through the same pipelined unit. The result then streams out in natural bin order as one unbroken run of valid cycles.

Every stage halves its results, so the output is the DFT divided by N. That scaling keeps the fixed-point words from overflowing. Twiddle factors come from a constant cosine/sine table that is computed when the design is elaborated. The FFT length is a power-of-two parameter: it is small by default and up to 512 is supported. All counter and address widths are derived from it.

The upstream source may pause on any cycle. Samples offered while ready is low are dropped and never reach the memory. Ready rises again only when the stored result has been read out far enough that the next frame can be written.

Top module: `fft_burst_r2`

## Requirements
- R1: A synchronous active-high `rst` sets `in_ready` to 1 and `out_valid` to 0. It also discards any partly collected frame, so the next accepted sample is index 0 of a new frame.
- R2: A sample is stored only on a cycle where `in_valid` and `in_ready` are both 1. In the cycle that follows the storing of the N-th sample, `in_ready` is 0.
- R3: While `in_ready` is 0, the values on `in_valid`, `in_re` and `in_im` have no effect on the stored frame or on any output value.
- R4: A cycle with `in_ready` high and `in_valid` low stores nothing and does not advance the sample count. The data lines on that cycle are ignored.
- R5: Output bin k equals (1/N)·Σ x[n]·e^(−j2πnk/N), where x[n] is the n-th accepted sample. Every real and imaginary part is within 4 LSB of that value. Data is two's complement, and each input component is assumed bounded by 2^(DATA_W−2) in magnitude.
- R6: The N bins leave on N consecutive cycles with `out_valid` high and no gap, bin 0 first and then in ascending order.
- R7: `in_ready` stays 0 from the cycle after the frame is complete until the cycle in which bin N−1 is presented. In that cycle it is 1 again.
- R8: The first output bin appears exactly log2(N)·(N/2+3)+2 cycles after the cycle in which the last sample of the frame is stored.
- R9: One butterfly is issued per compute cycle. No stage reads the memory until every write of the previous stage has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_re | input | DATA_W | Input sample, real part |
| in_im | input | DATA_W | Input sample, imaginary part |
| in_ready | output | 1 | Core can store an input sample this cycle |
| out_valid | output | 1 | Output bin present |
| out_re | output | DATA_W | Output bin, real part |
| out_im | output | DATA_W | Output bin, imaginary part |

## Verification
The transform is driven with several kinds of input frame, and each one singles out a different kind of fault:
- An impulse gives a flat spectrum, which shows plain scaling and ordering.
- A DC frame concentrates its energy in bin 0.
- A pure complex tone lands in one bin, which exposes twiddle-sign and bit-reversal mistakes.
- An alternating-sign frame targets the Nyquist bin, the last butterfly's subtract path.
- Random frames exercise every twiddle.

Frames arrive back to back, with continuous, alternating and random gaps, so the fill count is stressed. Junk samples are offered throughout the busy period and while valid is low. A reset in the middle of a frame shows that the partial fill is discarded. Exact cycle checks on the first output bin, the contiguous run and the return of ready pin down the schedule.

// File: rtl/fft_pkg.sv
package fft_pkg;
  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_CALC   = 2'd1,
    ST_FLUSH  = 2'd2,
    ST_DRAIN  = 2'd3
  } fft_phase_e;
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int N     = 16,
  parameter int TW_W  = 16
) (
  input  logic                   clk,
  input  logic [$clog2(N)-2:0]   idx,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im
);
  localparam int  HALF  = N / 2;
  localparam real SCALE = 2.0 ** (TW_W - 2);
  localparam real TWO_PI = 6.283185307179586;

  logic signed [TW_W-1:0] tab_re [HALF];
  logic signed [TW_W-1:0] tab_im [HALF];

  // W^k = exp(-j*2*pi*k/N), unity scaled by 2^(TW_W-2)
  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam real ANG = TWO_PI * k / N;
    localparam real CR  = $cos(ANG) * SCALE;
    localparam real CI  = -$sin(ANG) * SCALE;
    localparam int  IR  = $rtoi((CR >= 0.0) ? CR + 0.5 : CR - 0.5);
    localparam int  II  = $rtoi((CI >= 0.0) ? CI + 0.5 : CI - 0.5);
    assign tab_re[k] = TW_W'(IR);
    assign tab_im[k] = TW_W'(II);
  end

  always_ff @(posedge clk) begin
    w_re <= tab_re[idx];
    w_im <= tab_im[idx];
  end
endmodule

// File: rtl/fft_frame_mem.sv
module fft_frame_mem #(
  parameter int AW = 4,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] waddr_a,
  input  logic [WW-1:0] wdata_a,
  input  logic          we_b,
  input  logic [AW-1:0] waddr_b,
  input  logic [WW-1:0] wdata_b,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [WW-1:0] rdata_a,
  output logic [WW-1:0] rdata_b
);
  localparam int DEPTH = 2 ** AW;

  logic [WW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) cells[waddr_a] <= wdata_a;
    if (we_b) cells[waddr_b] <= wdata_b;
    rdata_a <= cells[raddr_a];
    rdata_b <= cells[raddr_b];
  end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
  parameter int DW   = 16,
  parameter int TW_W = 16,
  parameter int AW   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_v,
  input  logic [AW-1:0]         in_addr_a,
  input  logic [AW-1:0]         in_addr_b,
  input  logic signed [DW-1:0]  a_re,
  input  logic signed [DW-1:0]  a_im,
  input  logic signed [DW-1:0]  b_re,
  input  logic signed [DW-1:0]  b_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic                  wr_en,
  output logic [AW-1:0]         wr_addr_a,
  output logic [AW-1:0]         wr_addr_b,
  output logic signed [DW-1:0]  top_re,
  output logic signed [DW-1:0]  top_im,
  output logic signed [DW-1:0]  bot_re,
  output logic signed [DW-1:0]  bot_im
);
  localparam int FRAC = TW_W - 2;
  localparam int PW   = DW + TW_W + 1;
  localparam int QW   = DW + 2;
  localparam int SW   = DW + 3;
  localparam logic signed [SW-1:0] HI = signed'({{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [SW-1:0] LO = ~HI;

  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir, p_re_full, p_im_full;
  logic signed [QW-1:0] p_re_q, p_im_q;
  logic signed [DW-1:0] a_re_q, a_im_q;
  logic signed [SW-1:0] s_re, s_im, d_re, d_im;

  // complex product b * W at full precision
  always_comb begin
    m_rr = PW'(b_re) * PW'(w_re);
    m_ii = PW'(b_im) * PW'(w_im);
    m_ri = PW'(b_re) * PW'(w_im);
    m_ir = PW'(b_im) * PW'(w_re);
    p_re_full = m_rr - m_ii;
    p_im_full = m_ri + m_ir;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= in_v;
    p_re_q    <= QW'(p_re_full >>> FRAC);
    p_im_q    <= QW'(p_im_full >>> FRAC);
    a_re_q    <= a_re;
    a_im_q    <= a_im;
    wr_addr_a <= in_addr_a;
    wr_addr_b <= in_addr_b;
  end

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI)      clip = HI[DW-1:0];
    else if (v < LO) clip = LO[DW-1:0];
    else             clip = v[DW-1:0];
  endfunction

  // sum and difference, halved per stage
  always_comb begin
    s_re = (SW'(a_re_q) + SW'(p_re_q)) >>> 1;
    s_im = (SW'(a_im_q) + SW'(p_im_q)) >>> 1;
    d_re = (SW'(a_re_q) - SW'(p_re_q)) >>> 1;
    d_im = (SW'(a_im_q) - SW'(p_im_q)) >>> 1;
    top_re = clip(s_re);
    top_im = clip(s_im);
    bot_re = clip(d_re);
    bot_im = clip(d_im);
  end

  AST_BF_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr_a != wr_addr_b)); // R9
endmodule

// File: rtl/fft_burst_r2.sv
module fft_burst_r2 #(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  parameter int TW_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im
);
  import fft_pkg::*;

  localparam int AW   = $clog2(N);
  localparam int STW  = (AW > 1) ? $clog2(AW) : 1;
  localparam int WW   = 2 * DATA_W;
  localparam logic [STW-1:0] LAST_STAGE = STW'(AW - 1);

  fft_phase_e       phase;
  logic [AW-1:0]    fill;
  logic [AW-1:0]    fill_rev;
  logic [AW-2:0]    bfi;
  logic [STW-1:0]   stage;
  logic [AW-1:0]    uaddr;
  logic [AW-1:0]    out_cnt;

  logic [AW-1:0]    bfi_x, low_mask, ia, ib, tw_full, tw_sh;
  logic [AW-2:0]    tw_idx;
  logic             v1;
  logic [AW-1:0]    ia_q, ib_q;

  logic             take;
  logic [WW-1:0]    rd_a, rd_b;
  logic signed [TW_W-1:0] w_re, w_im;
  logic             bf_we;
  logic [AW-1:0]    bf_wa, bf_wb;
  logic signed [DATA_W-1:0] t_re, t_im, u_re, u_im;

  assign in_ready = (phase == ST_FILL);
  assign take     = in_valid && in_ready;

  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign fill_rev[i] = fill[AW-1-i];
  end

  // butterfly address generation for decimation-in-time stage 'stage'
  always_comb begin
    bfi_x    = AW'(bfi);
    low_mask = (AW'(1) << stage) - AW'(1);
    ia       = ((bfi_x & ~low_mask) << 1) | (bfi_x & low_mask);
    ib       = ia | (AW'(1) << stage);
    tw_sh    = AW'(AW - 1) - AW'(stage);
    tw_full  = (bfi_x & low_mask) << tw_sh;
    tw_idx   = tw_full[AW-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_FILL;
      fill  <= '0;
      bfi   <= '0;
      stage <= '0;
      uaddr <= '0;
    end else begin
      unique case (phase)
        ST_FILL: if (take) begin
          fill <= fill + AW'(1);
          if (fill == '1) begin
            phase <= ST_CALC;
            bfi   <= '0;
            stage <= '0;
          end
        end
        ST_CALC: begin
          bfi <= bfi + 1'b1;
          if (bfi == '1) phase <= ST_FLUSH;
        end
        ST_FLUSH: if (!v1 && !bf_we) begin
          if (stage == LAST_STAGE) begin
            phase <= ST_DRAIN;
            uaddr <= '0;
          end else begin
            stage <= stage + 1'b1;
            bfi   <= '0;
            phase <= ST_CALC;
          end
        end
        ST_DRAIN: begin
          uaddr <= uaddr + AW'(1);
          if (uaddr == '1) begin
            phase <= ST_FILL;
            fill  <= '0;
          end
        end
        default: phase <= ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
      out_cnt   <= '0;
    end else begin
      v1        <= (phase == ST_CALC);
      out_valid <= (phase == ST_DRAIN);
      if (out_valid) out_cnt <= out_cnt + AW'(1);
    end
    ia_q <= ia;
    ib_q <= ib;
  end

  fft_frame_mem #(.AW(AW), .WW(WW)) u_mem (
    .clk     (clk),
    .we_a    (take || bf_we),
    .waddr_a (take ? fill_rev : bf_wa),
    .wdata_a (take ? {in_re, in_im} : {t_re, t_im}),
    .we_b    (bf_we),
    .waddr_b (bf_wb),
    .wdata_b ({u_re, u_im}),
    .raddr_a ((phase == ST_DRAIN) ? uaddr : ia),
    .raddr_b (ib),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  fft_twiddle_rom #(.N(N), .TW_W(TW_W)) u_rom (
    .clk  (clk),
    .idx  (tw_idx),
    .w_re (w_re),
    .w_im (w_im)
  );

  fft_bfly #(.DW(DATA_W), .TW_W(TW_W), .AW(AW)) u_bfly (
    .clk       (clk),
    .rst       (rst),
    .in_v      (v1),
    .in_addr_a (ia_q),
    .in_addr_b (ib_q),
    .a_re      (rd_a[WW-1:DATA_W]),
    .a_im      (rd_a[DATA_W-1:0]),
    .b_re      (rd_b[WW-1:DATA_W]),
    .b_im      (rd_b[DATA_W-1:0]),
    .w_re      (w_re),
    .w_im      (w_im),
    .wr_en     (bf_we),
    .wr_addr_a (bf_wa),
    .wr_addr_b (bf_wb),
    .top_re    (t_re),
    .top_im    (t_im),
    .bot_re    (u_re),
    .bot_im    (u_im)
  );

  assign out_re = rd_a[WW-1:DATA_W];
  assign out_im = rd_a[DATA_W-1:0];

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (take && fill == '1) |=> !in_ready); // R2
  AST_BUSY_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && in_valid && phase != ST_DRAIN) |=> $stable(fill)); // R3
  AST_GAP_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(fill)); // R4
  AST_OUT_RUN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cnt != '1) |=> out_valid); // R6
  AST_READY_RETURN: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (out_valid && out_cnt == '1)); // R7
  AST_NO_HAZARD: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_CALC && bf_we) |-> (ia != bf_wa && ia != bf_wb && ib != bf_wa && ib != bf_wb)); // R9
endmodule

// File: tb/fft_burst_r2_bench.sv
module fft_burst_r2_bench;
  localparam int N      = 16;
  localparam int DW     = 16;
  localparam int AW     = 4;
  localparam int CLK_P  = 10;
  localparam int TOL    = 4;
  localparam int LAT    = AW * (N / 2 + 3) + 2;

  logic          clk, rst, in_valid, in_ready, out_valid;
  logic [DW-1:0] in_re, in_im, out_re, out_im;

  fft_burst_r2 #(.N(N), .DATA_W(DW), .TW_W(16)) u_fft_burst_r2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .in_ready(in_ready), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, errors = 0, cyc = 0;
  int xr [N], xi [N];
  int orr [N], oii [N];
  real er [N], ei [N];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp, int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(real v);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  function automatic int sgn(logic [DW-1:0] v);
    return int'(signed'(v));
  endfunction

  task automatic make_frame(int kind);
    for (int n = 0; n < N; n++) begin
      case (kind)
        0: begin xr[n] = (n == 0) ? 5000 : 0; xi[n] = 0; end
        1: begin xr[n] = 3000; xi[n] = -2000; end
        2: begin
          xr[n] = rnd(6000.0 * $cos(6.283185307179586 * 3 * n / N));
          xi[n] = rnd(6000.0 * $sin(6.283185307179586 * 3 * n / N));
        end
        4: begin xr[n] = (n % 2 == 0) ? 8191 : -8191; xi[n] = $urandom_range(0, 400) - 200; end
        default: begin xr[n] = $urandom_range(0, 16382) - 8191; xi[n] = $urandom_range(0, 16382) - 8191; end
      endcase
    end
    for (int k = 0; k < N; k++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < N; n++) begin
        ang = -6.283185307179586 * n * k / N;
        sr += xr[n] * $cos(ang) - xi[n] * $sin(ang);
        si += xr[n] * $sin(ang) + xi[n] * $cos(ang);
      end
      er[k] = sr / N;
      ei[k] = si / N;
    end
  endtask

  task automatic run_frame(int gap);
    int acc, ph, t, got, prev, bad;
    logic v;
    acc = 0; ph = 0;
    while (acc < N) begin
      @(negedge clk);
      v = (gap == 0) ? 1'b1 : (gap == 1) ? (ph % 2 == 0) : ($urandom_range(0, 9) > 3);
      ph++;
      in_valid = v;
      // R4: data on idle cycles is junk and must be ignored
      in_re = v ? DW'(xr[acc]) : DW'($urandom);
      in_im = v ? DW'(xi[acc]) : DW'($urandom);
      if (v && in_ready) acc++;
    end
    @(negedge clk);
    t = 1;
    chk("R2 ready low after full frame", int'(in_ready), 0, 0);
    got = 0; prev = 0;
    while (got < N && t < LAT + N + 20) begin
      if (out_valid) begin
        if (got == 0) chk("R8 first output cycle", t, LAT, 0);
        else          chk("R6 contiguous output", t - prev, 1, 0);
        chk("R7 ready during output", int'(in_ready), (got == N - 1) ? 1 : 0, 0);
        orr[got] = sgn(out_re);
        oii[got] = sgn(out_im);
        prev = t;
        got++;
      end else if (got == 0 && in_ready) begin
        chk("R7 ready low while computing", 1, 0, 0);
      end
      // R3: junk offered throughout the busy period
      in_valid = !in_ready;
      in_re = DW'($urandom);
      in_im = DW'($urandom);
      if (got < N) begin
        @(negedge clk);
        t++;
      end
    end
    chk("R6 output count", got, N, 0);
    bad = 0;
    for (int k = 0; k < got; k++) begin
      if (orr[k] > rnd(er[k]) + TOL || orr[k] < rnd(er[k]) - TOL ||
          oii[k] > rnd(ei[k]) + TOL || oii[k] < rnd(ei[k]) - TOL) bad++;
      chk("R5 bin real", orr[k], rnd(er[k]), TOL);
      chk("R5 bin imag", oii[k], rnd(ei[k]), TOL);
    end
    chk("R3 R4 frame unaffected by ignored samples", bad, 0, 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after reset", int'(in_ready), 1, 0);
    chk("R1 out_valid after reset", int'(out_valid), 0, 0);
    // partial frame, then reset: the partial fill must be discarded (R1)
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = DW'(i * 999); in_im = DW'(-i * 77);
    end
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after mid-frame reset", int'(in_ready), 1, 0);
    chk("R1 out_valid after mid-frame reset", int'(out_valid), 0, 0);

    make_frame(0); run_frame(0);   // impulse, continuous (R1 partial fill gone)
    make_frame(1); run_frame(1);   // DC, alternate gaps
    make_frame(2); run_frame(2);   // single tone, random gaps
    make_frame(3); run_frame(2);   // random, random gaps
    make_frame(4); run_frame(0);   // Nyquist-heavy, continuous
    make_frame(3); run_frame(1);   // random, alternate gaps
    make_frame(3); run_frame(0);   // random, continuous
    @(negedge clk);
    in_valid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule